// File: doc/BRIEF.md
# External CAS Signaling Inserter

This block merges channel-associated signaling into a serial E1 transmit stream. A serial signaling input is sampled on the transmit system clock. Sampling is referenced to a frame sync pulse that marks bit 1 of slot 0 of frame 0. A frame has 32 slots of 8 bits, which is 256 clocks, and a multiframe has 16 frames. In each ordinary slot, bits 5 to 8 are the signaling bits. Slots 0 and 16 are taken in full. The captured bits are held in a shadow store. They are then copied into an active store that drives the signaling positions of the outgoing data.

In CRC4/multiframe mode, the signaling input is read only during frame 15. The capture takes effect from frame 0 of the next multiframe, so the signaling pattern stays aligned to the CRC4 multiframe. Outside that mode, every frame is sampled and applied at the next frame boundary. An internal signaling controller can supply its own bits, and these take priority over the external signaling at any signaling position.

Top module: `cas_sig_inserter`

## Requirements
- R1: After reset, data_o is 0. Until the first capture has been applied, signaling positions pass data_i through, unless the internal override is active.
- R2: A sync_i pulse sets the current position to slot 0, bit 1, frame 0 in the same cycle, whatever the position counter held before.
- R3: In slots other than 0 and 16, bits 1 to 4 always carry data_i. Bit n of a slot is the n-th clock of that slot. data_o shows the merged bit one clock after its inputs are presented.
- R4: In slots 0 and 16, all 8 bit positions carry the captured signaling bits once a capture has been applied.
- R5: With crc4_mode_i set, sig_i is sampled only during frame 15. Its value in frames 0 to 14 has no effect on data_o.
- R6: With crc4_mode_i set, a capture from frame 15 is output at the same positions in all 16 frames of the following multiframe.
- R7: With crc4_mode_i clear, sig_i is sampled in every frame. Its value appears at the same position in the next frame.
- R8: At a signaling position with int_valid_i set, data_o takes int_data_i. At a non-signaling position, int_valid_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit system clock, one bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame sync, marks bit 1 of slot 0 of frame 0 |
| sig_i | input | 1 | Serial external signaling |
| data_i | input | 1 | Serial transmit data |
| crc4_mode_i | input | 1 | CRC4/multiframe capture mode |
| int_valid_i | input | 1 | Internal signaling controller owns this bit |
| int_data_i | input | 1 | Internal signaling bit |
| data_o | output | 1 | Merged serial transmit data |

## Verification
The bench runs in CRC4 mode while driving random signaling in every frame. A design that sampled outside frame 15 would leak those values into the next multiframe, and a design that copied the store at a frame boundary instead of the multiframe boundary would change signaling in the middle of a multiframe. The bench resyncs in the middle of a frame. A counter that ignored the pulse would put signaling into data bits 1 to 4. Random internal overrides are applied at all positions. A priority inverted against external data, or an override applied outside the signaling positions, would corrupt data_o. Slots 0 and 16 are checked bit by bit, which catches a decoder that treats them like ordinary slots.

// File: rtl/cas_ins_pkg.sv
package cas_ins_pkg;
  localparam int unsigned FRAME_SLOTS = 32;
  localparam int unsigned SLOT_BITS   = 8;
  localparam int unsigned MF_FRAMES   = 16;
  localparam int unsigned FULL_SLOT_A = 0;
  localparam int unsigned FULL_SLOT_B = 16;
  localparam int unsigned SIG_BIT_LO  = 4;  // bit index 4 is bit 5
endpackage

// File: rtl/cas_frame_timer.sv
module cas_frame_timer #(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned BITS   = 8,
  parameter int unsigned FRAMES = 16,
  localparam int unsigned PW = $clog2(SLOTS * BITS),
  localparam int unsigned FW = $clog2(FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  output logic [PW-1:0] pos_o,
  output logic [FW-1:0] frame_o,
  output logic          frame_end_o,
  output logic          mf_last_o
);
  localparam logic [PW-1:0] POS_LAST   = PW'(SLOTS * BITS - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAMES - 1);

  logic [PW-1:0] pos_q;
  logic [FW-1:0] frame_q;

  assign pos_o       = sync_i ? '0 : pos_q;
  assign frame_o     = sync_i ? '0 : frame_q;
  assign frame_end_o = (pos_o == POS_LAST);
  assign mf_last_o   = (frame_o == FRAME_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else begin
      pos_q <= frame_end_o ? '0 : pos_o + 1'b1;
      if (frame_end_o) frame_q <= mf_last_o ? '0 : frame_o + 1'b1;
      else             frame_q <= frame_o;
    end
  end
endmodule

// File: rtl/cas_slot_decode.sv
module cas_slot_decode #(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned BITS   = 8,
  parameter int unsigned SLOT_A = 0,
  parameter int unsigned SLOT_B = 16,
  parameter int unsigned BIT_LO = 4,
  localparam int unsigned PW = $clog2(SLOTS * BITS),
  localparam int unsigned BW = $clog2(BITS)
) (
  input  logic [PW-1:0] pos_i,
  output logic          sig_pos_o
);
  logic [SLOTS-1:0] full_mask;

  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign full_mask[s] = (s == SLOT_A) || (s == SLOT_B);
  end

  logic [PW-BW-1:0] slot;
  logic [BW-1:0]    bitn;
  assign slot = pos_i[PW-1:BW];
  assign bitn = pos_i[BW-1:0];

  assign sig_pos_o = full_mask[slot] || (bitn >= BW'(BIT_LO));
endmodule

// File: rtl/cas_sig_store.sv
module cas_sig_store #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             wr_bit_i,
  input  logic             xfer_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             rd_bit_o,
  output logic             armed_o,
  output logic [DEPTH-1:0] shadow_o,
  output logic [DEPTH-1:0] active_o
);
  logic [DEPTH-1:0] shadow_q, shadow_nx, active_q;
  logic             armed_q;

  always_comb begin
    shadow_nx = shadow_q;
    if (wr_en_i) shadow_nx[wr_addr_i] = wr_bit_i;
  end

  // copy includes a write landing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      shadow_q <= shadow_nx;
      if (xfer_i) begin
        active_q <= shadow_nx;
        armed_q  <= 1'b1;
      end
    end
  end

  assign rd_bit_o = active_q[rd_addr_i];
  assign armed_o  = armed_q;
  assign shadow_o = shadow_q;
  assign active_o = active_q;
endmodule

// File: rtl/cas_sig_inserter.sv
module cas_sig_inserter
  import cas_ins_pkg::*;
#(
  parameter int unsigned SLOTS  = FRAME_SLOTS,
  parameter int unsigned BITS   = SLOT_BITS,
  parameter int unsigned FRAMES = MF_FRAMES,
  parameter int unsigned SLOT_A = FULL_SLOT_A,
  parameter int unsigned SLOT_B = FULL_SLOT_B,
  parameter int unsigned BIT_LO = SIG_BIT_LO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic sig_i,
  input  logic data_i,
  input  logic crc4_mode_i,
  input  logic int_valid_i,
  input  logic int_data_i,
  output logic data_o
);
  localparam int unsigned DEPTH = SLOTS * BITS;
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned FW    = $clog2(FRAMES);

  logic [PW-1:0]    pos;
  logic [FW-1:0]    frame;
  logic             frame_end, mf_last, sig_pos, cap, xfer, act_bit, armed, mix_bit, data_q;
  logic [DEPTH-1:0] shadow, active;

  cas_frame_timer #(.SLOTS(SLOTS), .BITS(BITS), .FRAMES(FRAMES)) u_timer (
    .clk_i, .rst_ni, .sync_i,
    .pos_o(pos), .frame_o(frame), .frame_end_o(frame_end), .mf_last_o(mf_last)
  );

  cas_slot_decode #(
    .SLOTS(SLOTS), .BITS(BITS), .SLOT_A(SLOT_A), .SLOT_B(SLOT_B), .BIT_LO(BIT_LO)
  ) u_dec (.pos_i(pos), .sig_pos_o(sig_pos));

  // capture window: last frame of multiframe, or every frame
  assign cap  = crc4_mode_i ? mf_last : 1'b1;
  assign xfer = frame_end && cap;

  cas_sig_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(cap && sig_pos), .wr_addr_i(pos), .wr_bit_i(sig_i),
    .xfer_i(xfer), .rd_addr_i(pos), .rd_bit_o(act_bit), .armed_o(armed),
    .shadow_o(shadow), .active_o(active)
  );

  always_comb begin
    mix_bit = data_i;
    if (sig_pos) begin
      if (int_valid_i) mix_bit = int_data_i;
      else if (armed)  mix_bit = act_bit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= 1'b0;
    else         data_q <= mix_bit;
  end

  assign data_o = data_q;
endmodule

// File: rtl/cas_sig_inserter_chk.sv
module cas_sig_inserter_chk #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned BITS   = 8,
  parameter int unsigned FRAMES = 16,
  parameter int unsigned SLOT_A = 0,
  parameter int unsigned SLOT_B = 16,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned FW = $clog2(FRAMES),
  localparam int unsigned BW = $clog2(BITS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             data_i,
  input logic             crc4_mode_i,
  input logic             int_valid_i,
  input logic             int_data_i,
  input logic             data_o,
  input logic [PW-1:0]    pos,
  input logic [FW-1:0]    frame,
  input logic             sig_pos,
  input logic             xfer,
  input logic [DEPTH-1:0] shadow,
  input logic [DEPTH-1:0] active
);
  a_r2_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && $past(sync_i)) |-> pos == PW'(1));

  a_r3_data_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_pos |=> data_o == $past(data_i));

  a_r4_full_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos[PW-1:BW] == (PW-BW)'(SLOT_A) || pos[PW-1:BW] == (PW-BW)'(SLOT_B)) |-> sig_pos);

  a_r5_no_early_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc4_mode_i && frame != FW'(FRAMES - 1)) |=> $stable(shadow));

  a_r6_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(active));

  a_r8_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_pos && int_valid_i) |=> data_o == $past(int_data_i));
endmodule

bind cas_sig_inserter cas_sig_inserter_chk #(
  .DEPTH(DEPTH), .BITS(BITS), .FRAMES(FRAMES), .SLOT_A(SLOT_A), .SLOT_B(SLOT_B)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .data_i(data_i),
  .crc4_mode_i(crc4_mode_i), .int_valid_i(int_valid_i), .int_data_i(int_data_i),
  .data_o(data_o), .pos(pos), .frame(frame), .sig_pos(sig_pos), .xfer(xfer),
  .shadow(shadow), .active(active)
);

// File: tb/cas_sig_inserter_tb.sv
module cas_sig_inserter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync, sig, dat, crc4, iv, id;
  logic dout;

  always #2 clk = ~clk;

  cas_sig_inserter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sig_i(sig), .data_i(dat),
    .crc4_mode_i(crc4), .int_valid_i(iv), .int_data_i(id), .data_o(dout)
  );

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  string phase_tag = "";

  // reference model state
  int         m_pos = 0, m_frame = 0;
  logic [255:0] m_shadow = '0, m_active = '0;
  bit         m_armed = 0;

  task automatic step(input logic s_sync, input logic s_sig, input logic s_dat,
                      input logic s_crc4, input logic s_iv, input logic s_id);
    int    cur, f, slot, b;
    bit    sp, full, capw;
    logic  e;
    string t;
    @(negedge clk);
    sync = s_sync; sig = s_sig; dat = s_dat; crc4 = s_crc4; iv = s_iv; id = s_id;
    cur  = s_sync ? 0 : m_pos;
    f    = s_sync ? 0 : m_frame;
    slot = cur / 8;
    b    = cur % 8;
    full = (slot == 0) || (slot == 16);
    sp   = full || (b >= 4);
    if (!sp)        e = s_dat;
    else if (s_iv)  e = s_id;
    else if (m_armed) e = m_active[cur];
    else            e = s_dat;
    if (sp && s_iv)       t = "R8";
    else if (phase_tag != "") t = phase_tag;
    else if (!sp)         t = "R3";
    else if (!m_armed)    t = "R1";
    else if (full)        t = "R4";
    else if (!s_crc4)     t = "R7";
    else if (f < 8)       t = "R5";
    else                  t = "R6";
    exp_q.push_back('{val: e, tag: t});
    capw = s_crc4 ? (f == 15) : 1'b1;
    if (capw && sp) m_shadow[cur] = s_sig;
    if (cur == 255 && capw) begin
      m_active = m_shadow;
      m_armed  = 1;
    end
    if (cur == 255) begin
      m_pos   = 0;
      m_frame = (f + 1) % 16;
    end else begin
      m_pos   = cur + 1;
      m_frame = f;
    end
  endtask

  task automatic run(input int n, input logic c4, input int ov_pct, input bit first_sync);
    for (int i = 0; i < n; i++) begin
      logic v;
      v = (ov_pct > 0) && (($urandom % 100) < ov_pct);
      step(first_sync && i == 0, 1'($urandom), 1'($urandom), c4, v, 1'($urandom));
    end
  endtask

  // monitor: compares one cycle after each driven bit
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        n_run++;
        if (dout !== x.val) begin
          n_fail++;
          $display("FAIL %s: data_o=%b expected %b", x.tag, dout, x.val);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sync = 0; sig = 0; dat = 0; crc4 = 0; iv = 0; id = 0;
    repeat (3) @(negedge clk);
    dat = 1;
    @(negedge clk);
    n_run++;  // R1 reset state
    if (dout !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: data_o=%b expected 0", dout);
    end
    rst_n = 1;
    // frame mode: first frame unarmed, then per-frame capture
    run(4 * 256, 1'b0, 0, 1);
    // multiframe mode, random signaling in every frame
    run(3 * 16 * 256, 1'b1, 0, 1);
    // internal override bursts
    run(16 * 256, 1'b1, 30, 0);
    // resync mid-frame
    run(100, 1'b0, 0, 0);
    phase_tag = "R2";
    run(256, 1'b0, 0, 1);
    phase_tag = "";
    run(2 * 256, 1'b0, 10, 0);
    // back to multiframe after resync
    run(2 * 16 * 256, 1'b1, 0, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule